// File: doc/BRIEF.md
# Buffered Pulse Density Modulator

This block converts a 12-bit level into a one-bit stream whose fraction of ones equals the level divided by 4096. It uses a first-order phase accumulator. A downstream RC network, which is not part of this block, smooths the stream into a voltage.

New levels arrive as one-cycle write strobes carrying a data word. Every word lands in a holding register. It is then copied into the active register in one of two ways:

- **Direct update:** the copy happens at once.
- **Triggered update:** the copy waits for a pulse on one of four trigger inputs, chosen by a select field. This lets level changes line up with events elsewhere, such as a power-stage timing edge.

Each load of the active register also raises a one-cycle request. The request asks the downstream filter to switch to its fast-settling setting. A disable input suppresses the request for applications that cannot accept the extra ripple.

The recommended level range is 0x0CD to 0xF32, roughly 5% to 95% of full scale. Words outside that range are used unchanged.

Top module: `pdm_dac_core`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `pdm_out`, `tmode_req` and `level_out` are all 0.
- R2: With `en` high and a constant active level D, any 4096 consecutive output cycles carry exactly D ones. Level 0 gives no ones; level 4095 gives 4095 ones.
- R3: With `upd_on_trig` low, a word written with `wr_en` appears on `level_out` in the cycle after the strobe.
- R4: With `upd_on_trig` high, a written word leaves `level_out` unchanged until a pulse arrives on `trig_in[trig_sel]`. The word then appears in the cycle after that pulse.
- R5: With `upd_on_trig` high, two kinds of pulse change neither `level_out` nor `tmode_req`: a pulse on any trigger input other than `trig_in[trig_sel]`, and a selected pulse when no word is pending.
- R6: Each load of the active register produces `tmode_req` high for exactly the one cycle in which the new level first appears, provided `tmode_dis` is low.
- R7: With `tmode_dis` high, loads still take place but `tmode_req` stays low.
- R8: While `en` is low, `pdm_out` is 0 and the accumulator is held at zero. After `en` rises with level 2048, the outputs are 0, 1, 0, 1 on the four following cycles.
- R9: Words outside the recommended range, such as 0x001 and 0xFFF, are loaded unaltered.
- R10: If a write and a selected trigger occur in the same cycle in triggered mode, the trigger loads the previously pending word. The new word stays pending for the next trigger.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Modulator enable; low clears the accumulator and output |
| upd_on_trig | input | 1 | 1 = load the active register on the selected trigger, 0 = load on write |
| trig_sel | input | 2 | Index of the trigger input that is used |
| tmode_dis | input | 1 | Suppresses the fast-settling filter request |
| wr_en | input | 1 | One-cycle write strobe |
| wr_data | input | 12 | Written level |
| trig_in | input | 4 | Trigger pulses, one per source |
| pdm_out | output | 1 | Pulse density stream |
| tmode_req | output | 1 | One-cycle fast-settling filter request |
| level_out | output | 12 | Current active level |

## Verification
A corrupted accumulator or carry path shows up as a wrong count of ones within one 4096-cycle window. The error can look small at a single sample, so the ones are counted over whole windows rather than judged cycle by cycle.

A stale pending flag or holding register shows up on `level_out`, and on `tmode_req` firing or staying silent, in the cycle after the trigger that should or should not have loaded. Trigger pulses on unselected inputs expose a select that decodes the wrong index in a single cycle.

// File: rtl/pdm_pkg.sv
package pdm_pkg;

    localparam int PDM_DATA_W_DEF = 12;
    localparam int PDM_N_TRIG_DEF = 4;

    typedef enum logic {
        UPD_DIRECT    = 1'b0,
        UPD_TRIGGERED = 1'b1
    } upd_mode_e;

    // Which source, if any, feeds the active register this cycle.
    typedef enum logic [1:0] {
        LD_NONE  = 2'd0,
        LD_WRITE = 2'd1,
        LD_HOLD  = 2'd2
    } load_src_e;

    typedef struct packed {
        load_src_e src;
        logic      req;
    } load_evt_t;

    function automatic load_evt_t pick_load(
        input upd_mode_e mode,
        input logic      wr,
        input logic      hit,
        input logic      pending,
        input logic      req_dis
    );
        load_evt_t ev;
        ev.src = LD_NONE;
        if (mode == UPD_DIRECT) begin
            if (wr) ev.src = LD_WRITE;
        end else begin
            if (hit && pending) ev.src = LD_HOLD;
        end
        ev.req = (ev.src != LD_NONE) && !req_dis;
        return ev;
    endfunction

endpackage

// File: rtl/pdm_trig_pick.sv
module pdm_trig_pick #(
    parameter int N_TRIG = 4,
    localparam int SEL_W = (N_TRIG > 1) ? $clog2(N_TRIG) : 1
) (
    input  logic [N_TRIG-1:0] trig_in,
    input  logic [SEL_W-1:0]  sel,
    output logic              hit
);

    logic [N_TRIG-1:0] match;

    for (genvar i = 0; i < N_TRIG; i++) begin : g_src
        assign match[i] = trig_in[i] && (sel == SEL_W'(i));
    end

    assign hit = |match;

endmodule

// File: rtl/pdm_update_ctrl.sv
module pdm_update_ctrl
    import pdm_pkg::*;
#(
    parameter int DATA_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  upd_mode_e         mode,
    input  logic              req_dis,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              trig_hit,
    output logic [DATA_W-1:0] level,
    output logic              req
);

    logic [DATA_W-1:0] hold_q;
    logic [DATA_W-1:0] act_q;
    logic              pend_q;
    logic              req_q;

    load_evt_t         ev;
    logic [DATA_W-1:0] act_d;
    logic              pend_d;

    always_comb begin
        ev = pick_load(mode, wr_en, trig_hit, pend_q, req_dis);
        unique case (ev.src)
            LD_WRITE: act_d = wr_data;
            LD_HOLD:  act_d = hold_q;
            default:  act_d = act_q;
        endcase
        if (mode == UPD_DIRECT)  pend_d = 1'b0;
        else if (wr_en)          pend_d = 1'b1;
        else if (ev.src == LD_HOLD) pend_d = 1'b0;
        else                     pend_d = pend_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q <= '0;
            act_q  <= '0;
            pend_q <= 1'b0;
            req_q  <= 1'b0;
        end else begin
            if (wr_en) hold_q <= wr_data;
            act_q  <= act_d;
            pend_q <= pend_d;
            req_q  <= ev.req;
        end
    end

    assign level = act_q;
    assign req   = req_q;

endmodule

// File: rtl/pdm_phase_acc.sv
module pdm_phase_acc #(
    parameter int DATA_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic [DATA_W-1:0] level,
    output logic              bit_out
);

    localparam int SUM_W = DATA_W + 1;

    logic [DATA_W-1:0] acc_q;
    logic              bit_q;
    logic [SUM_W-1:0]  sum;

    assign sum = {1'b0, acc_q} + {1'b0, level};

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            acc_q <= '0;
            bit_q <= 1'b0;
        end else begin
            acc_q <= sum[DATA_W-1:0];
            bit_q <= sum[SUM_W-1];
        end
    end

    assign bit_out = bit_q;

endmodule

// File: rtl/pdm_dac_core.sv
module pdm_dac_core
    import pdm_pkg::*;
#(
    parameter int DATA_W = PDM_DATA_W_DEF,
    parameter int N_TRIG = PDM_N_TRIG_DEF,
    localparam int SEL_W = (N_TRIG > 1) ? $clog2(N_TRIG) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              upd_on_trig,
    input  logic [SEL_W-1:0]  trig_sel,
    input  logic              tmode_dis,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [N_TRIG-1:0] trig_in,
    output logic              pdm_out,
    output logic              tmode_req,
    output logic [DATA_W-1:0] level_out
);

    upd_mode_e         mode;
    logic              hit;
    logic [DATA_W-1:0] level;

    assign mode = upd_on_trig ? UPD_TRIGGERED : UPD_DIRECT;

    pdm_trig_pick #(.N_TRIG(N_TRIG)) u_pick (
        .trig_in (trig_in),
        .sel     (trig_sel),
        .hit     (hit)
    );

    pdm_update_ctrl #(.DATA_W(DATA_W)) u_upd (
        .clk      (clk),
        .rst      (rst),
        .mode     (mode),
        .req_dis  (tmode_dis),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .trig_hit (hit),
        .level    (level),
        .req      (tmode_req)
    );

    pdm_phase_acc #(.DATA_W(DATA_W)) u_acc (
        .clk     (clk),
        .rst     (rst),
        .en      (en),
        .level   (level),
        .bit_out (pdm_out)
    );

    assign level_out = level;

endmodule

// File: rtl/pdm_dac_core_chk.sv
module pdm_dac_core_chk #(
    parameter int DATA_W = 12,
    parameter int N_TRIG = 4,
    localparam int SEL_W = (N_TRIG > 1) ? $clog2(N_TRIG) : 1
) (
    input logic              clk,
    input logic              rst,
    input logic              en,
    input logic              upd_on_trig,
    input logic [SEL_W-1:0]  trig_sel,
    input logic              tmode_dis,
    input logic              wr_en,
    input logic [DATA_W-1:0] wr_data,
    input logic [N_TRIG-1:0] trig_in,
    input logic              pdm_out,
    input logic              tmode_req,
    input logic [DATA_W-1:0] level_out
);

    AST_OFF_LOW: assert property (@(posedge clk) disable iff (rst)
        !en |=> !pdm_out); // R8

    AST_DIRECT_LOAD: assert property (@(posedge clk) disable iff (rst)
        (!upd_on_trig && wr_en) |=> (level_out == $past(wr_data))); // R3

    AST_TRIG_WAIT: assert property (@(posedge clk) disable iff (rst)
        (upd_on_trig && !trig_in[trig_sel]) |=> $stable(level_out)); // R4

    AST_REQ_DISABLED: assert property (@(posedge clk) disable iff (rst)
        tmode_dis |=> !tmode_req); // R7

    AST_REQ_CAUSE: assert property (@(posedge clk) disable iff (rst)
        tmode_req |-> $past(wr_en || trig_in[trig_sel])); // R6

    AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (rst)
        !(wr_en || (|trig_in)) |=> $stable(level_out)); // R5

endmodule

bind pdm_dac_core pdm_dac_core_chk #(.DATA_W(DATA_W), .N_TRIG(N_TRIG)) u_chk (.*);

// File: tb/sim_pdm_dac_core.sv
`timescale 1ns/1ps
module sim_pdm_dac_core;

    localparam int DW = 12;
    localparam int NT = 4;

    logic          clk = 1'b0;
    logic          rst;
    logic          en;
    logic          upd_on_trig;
    logic [1:0]    trig_sel;
    logic          tmode_dis;
    logic          wr_en;
    logic [DW-1:0] wr_data;
    logic [NT-1:0] trig_in;
    logic          pdm_out;
    logic          tmode_req;
    logic [DW-1:0] level_out;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;
    logic [DW-1:0] exp_level;

    always #2 clk = ~clk;

    pdm_dac_core #(.DATA_W(DW), .N_TRIG(NT)) u0 (
        .clk(clk), .rst(rst), .en(en), .upd_on_trig(upd_on_trig),
        .trig_sel(trig_sel), .tmode_dis(tmode_dis), .wr_en(wr_en),
        .wr_data(wr_data), .trig_in(trig_in), .pdm_out(pdm_out),
        .tmode_req(tmode_req), .level_out(level_out)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Write strobe; returns after the edge that samples it.
    task automatic do_write(input logic [DW-1:0] v);
        @(negedge clk);
        wr_en = 1'b1; wr_data = v;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic pulse(input int idx);
        @(negedge clk);
        trig_in = '0; trig_in[idx] = 1'b1;
        @(negedge clk);
        trig_in = '0;
    endtask

    task automatic density(input logic [DW-1:0] v);
        int ones;
        do_write(v);
        @(negedge clk);
        @(negedge clk);
        ones = 0;
        for (int i = 0; i < 4096; i++) begin
            ones += int'(pdm_out);
            @(negedge clk);
        end
        check(ones == int'(v), "R2 density", ones, int'(v));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; en = 1'b0; upd_on_trig = 1'b0; trig_sel = 2'd0;
        tmode_dis = 1'b0; wr_en = 1'b0; wr_data = '0; trig_in = '0;
        repeat (3) @(negedge clk);
        check(pdm_out == 1'b0, "R1 out in reset", int'(pdm_out), 0);
        check(tmode_req == 1'b0, "R1 req in reset", int'(tmode_req), 0);
        check(level_out == '0, "R1 level in reset", int'(level_out), 0);
        rst = 1'b0;
        en  = 1'b1;
        @(negedge clk);
        check(pdm_out == 1'b0 && tmode_req == 1'b0 && level_out == '0,
              "R1 after reset", int'(level_out), 0);

        // Direct update, request pulse
        foreach (exp_level[b]) begin
            logic [DW-1:0] v;
            v = DW'(12'h5A3 ^ (12'h111 << (b % 3))) + DW'(b);
            do_write(v);
            check(level_out == v, "R3 direct load", int'(level_out), int'(v));
            check(tmode_req == 1'b1, "R6 req on load", int'(tmode_req), 1);
            @(negedge clk);
            check(tmode_req == 1'b0, "R6 req one cycle", int'(tmode_req), 0);
        end

        // Out-of-range words
        do_write(12'h001);
        check(level_out == 12'h001, "R9 low word", int'(level_out), 1);
        do_write(12'hFFF);
        check(level_out == 12'hFFF, "R9 high word", int'(level_out), 4095);

        // Request suppression
        tmode_dis = 1'b1;
        do_write(12'h3C7);
        check(level_out == 12'h3C7, "R7 load still done", int'(level_out), 12'h3C7);
        check(tmode_req == 1'b0, "R7 req suppressed", int'(tmode_req), 0);
        tmode_dis = 1'b0;

        // Density sweep
        density(12'h000);
        density(12'h001);
        density(12'h0CD);
        density(12'hF32);
        density(12'hFFE);
        density(12'hFFF);
        for (int k = 1; k < 16; k++) density(DW'(k * 257));

        // Triggered update, every select value
        exp_level = level_out;
        upd_on_trig = 1'b1;
        for (int s = 0; s < NT; s++) begin
            logic [DW-1:0] v;
            trig_sel = 2'(s);
            v = DW'(12'h210 + s * 12'h2F1);
            do_write(v);
            check(level_out == exp_level, "R4 held until trigger", int'(level_out), int'(exp_level));
            check(tmode_req == 1'b0, "R4 no req on write", int'(tmode_req), 0);
            for (int o = 0; o < NT; o++) begin
                if (o != s) begin
                    pulse(o);
                    check(level_out == exp_level && tmode_req == 1'b0,
                          "R5 unselected trigger", int'(level_out), int'(exp_level));
                end
            end
            pulse(s);
            exp_level = v;
            check(level_out == v, "R4 load on trigger", int'(level_out), int'(v));
            check(tmode_req == 1'b1, "R6 req on trigger load", int'(tmode_req), 1);
            pulse(s);
            check(level_out == v && tmode_req == 1'b0,
                  "R5 trigger with nothing pending", int'(tmode_req), 0);
        end

        // Write and trigger in the same cycle
        trig_sel = 2'd1;
        do_write(12'hA11);
        @(negedge clk);
        wr_en = 1'b1; wr_data = 12'h4B2; trig_in = 4'b0010;
        @(negedge clk);
        wr_en = 1'b0; trig_in = '0;
        check(level_out == 12'hA11, "R10 trigger takes older word", int'(level_out), 12'hA11);
        pulse(1);
        check(level_out == 12'h4B2, "R10 newer word stays pending", int'(level_out), 12'h4B2);

        // Enable behaviour
        upd_on_trig = 1'b0;
        en = 1'b0;
        do_write(12'd2048);
        begin
            int ones;
            ones = 0;
            for (int i = 0; i < 20; i++) begin
                @(negedge clk);
                ones += int'(pdm_out);
            end
            check(ones == 0, "R8 output low while disabled", ones, 0);
        end
        en = 1'b1;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            check(pdm_out == 1'(i % 2), "R8 restart from zero", int'(pdm_out), i % 2);
        end

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule